// File: doc/BRIEF.md
# SPI Serial EEPROM Device Model

A synthesizable SPI slave (mode 0) that answers like a small byte-addressed serial EEPROM. Its purpose is to be the target device for an SPI master under test. The master can read and write bytes, poll a status byte, and set or clear a write-enable latch. It also sees a realistic busy period after each write. The model stores data in an internal RAM and does not retain anything across power cycles.

The SPI pins are oversampled by the system clock through synchronizers, so SCK must be much slower than the system clock.

Write data is collected into a page-sized buffer. It is copied into the RAM only when chip select rises on a byte boundary. During the copy the busy bit is set for a programmable number of system clocks. The following are all parameters:
- the number of address bytes;
- whether opcode bit 3 acts as an extra top address bit;
- the page size;
- the busy time.

Top module: `spi_eeprom_model`

## Requirements
- R1: After reset the status byte is 0x00, and `spi_miso` is 0 while chip select is high. MISO data changes on the falling SCK edge, and bytes are shifted out most significant bit first.
- R2: Command 0x05 returns the status byte on every following byte for as long as chip select stays low. The status byte layout is bit 7 = protect enable, bits 3:2 = block protect, bit 1 = write-enable latch, bit 0 = busy, and all other bits 0.
- R3: Command 0x06 sets the write-enable latch (status bit 1), and command 0x04 clears it.
- R4: A write command (0x02) issued while the write-enable latch is clear changes no memory location and does not start a busy period.
- R5: Command 0x03 is followed by the address, most significant byte first. It then returns consecutive bytes for as long as chip select is low, and the address wraps from the last location of memory to location 0.
- R6: Command 0x02 is followed by the address and then data bytes. Each data byte goes to the next address, and when the address passes the end of the page it wraps back to the start of the same page.
- R7: With the extra-address-bit option on (the default), opcode bit 3 is used as address bit 8 for reads and writes (0x0B reads and 0x0A writes the upper 256 bytes).
- R8: A write, or a status write, that is accepted sets status bit 0 for exactly BUSY_CLKS system clocks, starting one clock after chip select rises. The write-enable latch clears when the busy period starts.
- R9: While busy, every command other than 0x05 is ignored. An ignored command drives MISO low and changes no state.
- R10: A write whose chip select rises in the middle of a byte is discarded. No memory changes, no busy period starts, and the write-enable latch stays set.
- R11: Command 0x01 with the write-enable latch set loads status bits 7, 3 and 2 from the first data byte, starts a busy period, and clears the latch. Without the latch set it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, registered |

## Verification
The assertions assume that SCK, MOSI and chip select are slow compared with the system clock. Each SCK half period must cover several system clocks, so every edge passes through the synchronizers before the next one. MOSI must only change while SCK is low. The stimulus keeps to these limits by using SCK half periods of eight system clocks, a gap of at least sixteen clocks between transfers, and chip select edges only while SCK is low. MOSI is changed a full half period before each rising SCK edge.

// File: rtl/spi_eep_pkg.sv
package spi_eep_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_A8_MASK = 8'hF7;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_RD,
    ST_WR,
    ST_RDSR,
    ST_WRSR,
    ST_SKIP
  } eep_state_e;

endpackage

// File: rtl/spi_eep_link.sv
module spi_eep_link #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck_i,
  input  logic       cs_n_i,
  input  logic       mosi_i,
  input  logic [7:0] tx_byte,
  output logic       cs_act,
  output logic       cs_rise,
  output logic [2:0] bit_cnt,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       tx_load,
  output logic       miso
);

  logic [SYNC_STAGES-1:0] sck_m, cs_m, mosi_m;
  logic sck_d, cs_d;
  logic sck_s, cs_s, mosi_s;
  logic sck_up, sck_dn;
  logic [6:0] rx_sr, tx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_m  <= '0;
      cs_m   <= '1;
      mosi_m <= '0;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sck_m  <= {sck_m[SYNC_STAGES-2:0], sck_i};
      cs_m   <= {cs_m[SYNC_STAGES-2:0], cs_n_i};
      mosi_m <= {mosi_m[SYNC_STAGES-2:0], mosi_i};
      sck_d  <= sck_s;
      cs_d   <= cs_s;
    end
  end

  always_comb begin
    sck_s   = sck_m[SYNC_STAGES-1];
    cs_s    = cs_m[SYNC_STAGES-1];
    mosi_s  = mosi_m[SYNC_STAGES-1];
    cs_act  = !cs_s;
    cs_rise = cs_s && !cs_d;
    sck_up  = sck_s && !sck_d && cs_act;
    sck_dn  = !sck_s && sck_d && cs_act;
    tx_load = sck_dn && (bit_cnt == 3'd0);
  end

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      byte_done <= 1'b0;
      miso      <= 1'b0;
      if (rst) rx_byte <= '0;
    end else begin
      byte_done <= 1'b0;
      if (sck_up) begin
        rx_sr   <= {rx_sr[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_done <= 1'b1;
          rx_byte   <= {rx_sr, mosi_s};
        end
      end
      if (sck_dn) begin
        if (bit_cnt == 3'd0) begin
          miso  <= tx_byte[7];
          tx_sr <= tx_byte[6:0];
        end else begin
          miso  <= tx_sr[6];
          tx_sr <= {tx_sr[5:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/spi_eep_ram.sv
module spi_eep_ram #(
  parameter int AW = 9,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/spi_eep_ctrl.sv
module spi_eep_ctrl
  import spi_eep_pkg::*;
#(
  parameter int ADDR_BYTES = 1,
  parameter int OPCODE_A8  = 1,
  parameter int PAGE_BYTES = 16,
  parameter int BUSY_CLKS  = 600,
  localparam int LOW_W  = 8 * ADDR_BYTES,
  localparam int ADDR_W = LOW_W + OPCODE_A8,
  localparam int PAGE_W = $clog2(PAGE_BYTES),
  localparam int BUSY_W = $clog2(BUSY_CLKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_rise,
  input  logic [2:0]        bit_cnt,
  input  logic              byte_done,
  input  logic [7:0]        rx_byte,
  input  logic              tx_load,
  output logic [7:0]        tx_byte,
  output logic [7:0]        status,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [7:0]        mem_rdata
);

  eep_state_e st_q;
  logic wel_q, wpen_q, busy;
  logic [1:0] bp_q;
  logic [BUSY_W-1:0] busy_q;
  logic wr_mode_q, hi_q;
  logic [LOW_W-1:0] abuf_q, abuf_nx;
  logic [1:0] aleft_q;
  logic [ADDR_W-1:0] rd_ptr_q, full_addr;
  logic [PAGE_W-1:0] off_q, cidx_q;
  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic [7:0] pb_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;
  logic any_q, commit_q;
  logic [2:0] srn_q;
  logic srh_q;
  logic [7:0] opc;

  always_comb begin
    busy      = (busy_q != '0);
    status    = {wpen_q, 3'b000, bp_q, wel_q, busy};
    opc       = (OPCODE_A8 != 0) ? (rx_byte & OP_A8_MASK) : rx_byte;
    abuf_nx   = (abuf_q << 8) | LOW_W'(rx_byte);
    full_addr = ADDR_W'({hi_q, abuf_nx});
    case (st_q)
      ST_RDSR: tx_byte = status;
      ST_RD:   tx_byte = mem_rdata;
      default: tx_byte = 8'h00;
    endcase
    mem_we    = commit_q && vld_q[cidx_q];
    mem_waddr = {page_q, cidx_q};
    mem_wdata = pb_q[cidx_q];
    mem_raddr = rd_ptr_q;
  end

  // page buffer: no reset, so it maps to plain storage
  always_ff @(posedge clk) begin
    if (byte_done && st_q == ST_WR) pb_q[off_q] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_CMD;
      wel_q     <= 1'b0;
      wpen_q    <= 1'b0;
      bp_q      <= '0;
      busy_q    <= '0;
      wr_mode_q <= 1'b0;
      hi_q      <= 1'b0;
      abuf_q    <= '0;
      aleft_q   <= '0;
      rd_ptr_q  <= '0;
      off_q     <= '0;
      cidx_q    <= '0;
      page_q    <= '0;
      vld_q     <= '0;
      any_q     <= 1'b0;
      commit_q  <= 1'b0;
      srn_q     <= '0;
      srh_q     <= 1'b0;
    end else begin
      if (busy) busy_q <= busy_q - BUSY_W'(1);
      if (commit_q) begin
        cidx_q <= cidx_q + PAGE_W'(1);
        if (cidx_q == PAGE_W'(PAGE_BYTES - 1)) commit_q <= 1'b0;
      end
      if (tx_load && st_q == ST_RD) rd_ptr_q <= rd_ptr_q + ADDR_W'(1);

      if (cs_rise) begin
        st_q  <= ST_CMD;
        any_q <= 1'b0;
        srh_q <= 1'b0;
        if (bit_cnt == 3'd0 &&
            ((st_q == ST_WR && any_q) || (st_q == ST_WRSR && srh_q))) begin
          wel_q  <= 1'b0;
          busy_q <= BUSY_W'(BUSY_CLKS);
          if (st_q == ST_WR) begin
            commit_q <= 1'b1;
            cidx_q   <= '0;
          end else begin
            wpen_q <= srn_q[2];
            bp_q   <= srn_q[1:0];
          end
        end
      end else if (byte_done) begin
        case (st_q)
          ST_CMD: begin
            if (busy) begin
              st_q <= (opc == OP_RDSR) ? ST_RDSR : ST_SKIP;
            end else begin
              hi_q    <= rx_byte[3];
              abuf_q  <= '0;
              aleft_q <= 2'(ADDR_BYTES - 1);
              st_q    <= ST_SKIP;
              case (opc)
                OP_WREN: wel_q <= 1'b1;
                OP_WRDI: wel_q <= 1'b0;
                OP_RDSR: st_q  <= ST_RDSR;
                OP_WRSR: if (wel_q) st_q <= ST_WRSR;
                OP_READ: begin
                  wr_mode_q <= 1'b0;
                  st_q      <= ST_ADDR;
                end
                OP_WRITE: if (wel_q) begin
                  wr_mode_q <= 1'b1;
                  st_q      <= ST_ADDR;
                end
                default: ;
              endcase
            end
          end
          ST_ADDR: begin
            abuf_q  <= abuf_nx;
            aleft_q <= aleft_q - 2'd1;
            if (aleft_q == 2'd0) begin
              if (wr_mode_q) begin
                page_q <= full_addr[ADDR_W-1:PAGE_W];
                off_q  <= full_addr[PAGE_W-1:0];
                vld_q  <= '0;
                st_q   <= ST_WR;
              end else begin
                rd_ptr_q <= full_addr;
                st_q     <= ST_RD;
              end
            end
          end
          ST_WR: begin
            vld_q[off_q] <= 1'b1;
            off_q        <= off_q + PAGE_W'(1);
            any_q        <= 1'b1;
          end
          ST_WRSR: if (!srh_q) begin
            srn_q <= {rx_byte[7], rx_byte[3:2]};
            srh_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_eeprom_model.sv
module spi_eeprom_model #(
  parameter int ADDR_BYTES  = 1,
  parameter int OPCODE_A8   = 1,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CLKS   = 600,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso
);

  localparam int ADDR_W = 8 * ADDR_BYTES + OPCODE_A8;

  logic              cs_act, cs_rise, byte_done, tx_load, mem_we;
  logic [2:0]        bit_cnt;
  logic [7:0]        rx_byte, tx_byte, status, mem_wdata, mem_rdata;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;

  spi_eep_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
    .clk(clk), .rst(rst), .sck_i(spi_sck), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .tx_byte(tx_byte), .cs_act(cs_act), .cs_rise(cs_rise), .bit_cnt(bit_cnt),
    .byte_done(byte_done), .rx_byte(rx_byte), .tx_load(tx_load), .miso(spi_miso)
  );

  spi_eep_ctrl #(
    .ADDR_BYTES(ADDR_BYTES), .OPCODE_A8(OPCODE_A8),
    .PAGE_BYTES(PAGE_BYTES), .BUSY_CLKS(BUSY_CLKS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cs_rise(cs_rise), .bit_cnt(bit_cnt),
    .byte_done(byte_done), .rx_byte(rx_byte), .tx_load(tx_load),
    .tx_byte(tx_byte), .status(status), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
  );

  spi_eep_ram #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

endmodule

// File: rtl/spi_eep_chk.sv
module spi_eep_chk #(
  parameter int BUSY_CLKS = 600
) (
  input logic clk,
  input logic rst,
  input logic miso,
  input logic cs_act,
  input logic cs_rise,
  input logic st_busy,
  input logic st_wel,
  input logic mem_we
);

  logic [31:0] run_len;

  always_ff @(posedge clk) begin
    if (rst || !st_busy) run_len <= '0;
    else                 run_len <= run_len + 32'd1;
  end

  // R1
  miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_act && $past(!cs_act)) |-> !miso);

  // R3
  wel_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st_wel) |-> !st_busy);

  // R8
  wel_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st_busy) |-> !st_wel);

  // R8
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(st_busy) |-> run_len == BUSY_CLKS);

  // R9
  wr_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> st_busy);

  // R10
  busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st_busy) |-> $past(cs_rise));

endmodule

bind spi_eeprom_model spi_eep_chk #(.BUSY_CLKS(BUSY_CLKS)) u_chk (
  .clk(clk), .rst(rst), .miso(spi_miso), .cs_act(cs_act), .cs_rise(cs_rise),
  .st_busy(status[0]), .st_wel(status[1]), .mem_we(mem_we)
);

// File: tb/test_spi_eeprom_model.sv
module test_spi_eeprom_model;

  localparam int HP   = 8;
  localparam int BUSY = 600;

  logic clk = 1'b0;
  logic rst, cs_n, sck, mosi;
  logic miso;

  always #5 clk = ~clk;

  spi_eeprom_model #(.BUSY_CLKS(BUSY)) i_spi_eeprom_model (
    .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck),
    .spi_mosi(mosi), .spi_miso(miso)
  );

  int nchk = 0;
  int nfail = 0;
  int idle = 0;

  logic [7:0] tx_b [16];
  logic [7:0] rx_b [16];
  logic [7:0] m_mem [512];
  bit m_wel = 0, m_busy = 0, m_wpen = 0;
  bit [1:0] m_bp = 0;

  task automatic wait_clk(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] m_status();
    return {m_wpen, 3'b000, m_bp, m_wel, m_busy};
  endfunction

  // R1: MISO stays low while chip select is idle, checked every clock
  always @(negedge clk) begin
    if (rst || !cs_n) idle = 0;
    else idle++;
    if (idle > 6) check("R1", {7'd0, miso}, 8'h00);
  end

  task automatic xfer(int n, int extra);
    cs_n = 1'b0;
    wait_clk(HP);
    for (int b = 0; b < n * 8 + extra; b++) begin
      mosi = tx_b[b / 8][7 - (b % 8)];
      wait_clk(HP);
      if (b / 8 < n) rx_b[b / 8][7 - (b % 8)] = miso;
      sck = 1'b1;
      wait_clk(HP);
      sck = 1'b0;
    end
    wait_clk(HP);
    cs_n = 1'b1;
    mosi = 1'b0;
    wait_clk(2 * HP);
  endtask

  // behavioural reference: predicts MISO bytes and updates the model state
  task automatic send(string tag, int n, int extra, logic [7:0] b0,
                      logic [7:0] b1 = 0, logic [7:0] b2 = 0, logic [7:0] b3 = 0,
                      logic [7:0] b4 = 0, logic [7:0] b5 = 0);
    logic [7:0] exp_b [16];
    int op, a, base;
    for (int i = 0; i < 16; i++) begin
      exp_b[i] = 8'h00;
      tx_b[i]  = 8'h00;
    end
    tx_b[0] = b0; tx_b[1] = b1; tx_b[2] = b2;
    tx_b[3] = b3; tx_b[4] = b4; tx_b[5] = b5;
    op = int'(b0 & 8'hF7);
    a  = (b0[3] ? 256 : 0) + int'(b1);
    if (m_busy) begin
      if (op == 5) for (int i = 1; i < n; i++) exp_b[i] = m_status();
    end else begin
      case (op)
        6: m_wel = 1;
        4: m_wel = 0;
        5: for (int i = 1; i < n; i++) exp_b[i] = m_status();
        1: if (m_wel && n >= 2 && extra == 0) begin
          m_wpen = b1[7];
          m_bp   = b1[3:2];
          m_wel  = 0;
          m_busy = 1;
        end
        3: for (int i = 2; i < n; i++) exp_b[i] = m_mem[(a + i - 2) % 512];
        2: if (m_wel && n >= 3 && extra == 0) begin
          base = a - (a % 16);
          for (int i = 2; i < n; i++) m_mem[base + ((a % 16) + i - 2) % 16] = tx_b[i];
          m_wel  = 0;
          m_busy = 1;
        end
        default: ;
      endcase
    end
    xfer(n, extra);
    for (int i = 0; i < n; i++) check(tag, rx_b[i], exp_b[i]);
  endtask

  task automatic settle();
    wait_clk(BUSY + 100);
    m_busy = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst = 1'b1; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0;
    for (int i = 0; i < 512; i++) m_mem[i] = 8'h00;
    wait_clk(10);
    rst = 1'b0;
    wait_clk(5);
    check("R1", {7'd0, miso}, 8'h00);
    send("R2", 3, 0, 8'h05);

    // R3: latch set and clear
    send("R3", 1, 0, 8'h06);
    send("R2", 3, 0, 8'h05);
    send("R3", 1, 0, 8'h04);
    send("R3", 2, 0, 8'h05);

    // R8: accepted write, busy visible, latch cleared
    send("R3", 1, 0, 8'h06);
    send("R6", 5, 0, 8'h02, 8'h20, 8'hA0, 8'hA1, 8'hA2);
    send("R8", 3, 0, 8'h05);
    settle();
    send("R8", 2, 0, 8'h05);
    send("R5", 5, 0, 8'h03, 8'h20);

    // R4: write without latch
    send("R4", 3, 0, 8'h02, 8'h20, 8'h55);
    send("R4", 2, 0, 8'h05);
    send("R4", 3, 0, 8'h03, 8'h20);

    // R6: page wrap
    send("R3", 1, 0, 8'h06);
    send("R6", 3, 0, 8'h02, 8'h40, 8'h99);
    settle();
    send("R3", 1, 0, 8'h06);
    send("R6", 6, 0, 8'h02, 8'h3E, 8'h11, 8'h22, 8'h33, 8'h44);
    settle();
    send("R6", 5, 0, 8'h03, 8'h3E);
    send("R6", 4, 0, 8'h03, 8'h30);

    // R7: opcode bit 3 as address bit 8
    send("R3", 1, 0, 8'h06);
    send("R7", 3, 0, 8'h0A, 8'h20, 8'h5A);
    settle();
    send("R7", 3, 0, 8'h0B, 8'h20);
    send("R7", 3, 0, 8'h03, 8'h20);

    // R5: read wraps at the end of memory
    send("R3", 1, 0, 8'h06);
    send("R7", 3, 0, 8'h0A, 8'hFF, 8'hC3);
    settle();
    send("R3", 1, 0, 8'h06);
    send("R6", 3, 0, 8'h02, 8'h00, 8'h3C);
    settle();
    send("R5", 4, 0, 8'h0B, 8'hFF);

    // R10: chip select rises mid-byte
    send("R3", 1, 0, 8'h06);
    send("R6", 3, 0, 8'h02, 8'h50, 8'h66);
    settle();
    send("R3", 1, 0, 8'h06);
    send("R10", 3, 3, 8'h02, 8'h50, 8'h77);
    send("R10", 2, 0, 8'h05);
    send("R10", 3, 0, 8'h03, 8'h50);
    send("R3", 1, 0, 8'h04);

    // R9: commands during busy are ignored
    send("R3", 1, 0, 8'h06);
    send("R6", 3, 0, 8'h02, 8'h60, 8'hE1);
    send("R9", 1, 0, 8'h06);
    send("R9", 4, 0, 8'h03, 8'h60);
    settle();
    send("R9", 2, 0, 8'h05);
    send("R9", 3, 0, 8'h03, 8'h60);

    // R11: status write
    send("R11", 2, 0, 8'h01, 8'h8C);
    send("R11", 2, 0, 8'h05);
    send("R3", 1, 0, 8'h06);
    send("R11", 2, 0, 8'h01, 8'hFF);
    send("R11", 3, 0, 8'h05);
    settle();
    send("R11", 2, 0, 8'h05);

    finish_run();
  end

endmodule